// File: doc/BRIEF.md
# 64-bit Alarm Timer with Prescaler

This block keeps a 64-bit time base that steps up or down once per prescaled tick. Software reaches it through a plain word-addressed register port with 32-bit data. It never reads the live counter. Instead, a write to a trigger register freezes the count into a pair of read-back words. A second trigger register copies a preloaded 64-bit value into the counter.

An armed alarm fires when the count equals a 64-bit compare value. When it fires, it sets a raw interrupt bit and disarms itself. It can also reload the counter with the preload value. Two interrupt outputs follow from an alarm:
- a level output, which is held until software clears the raw bit;
- a single-cycle edge pulse.

The register port has no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` is a combinational view of the addressed register, so a read needs no handshake.

Top module: `alarm_timer64`

## Requirements
- R1: After reset every register reads 0, the counter is 0 and both interrupt outputs are low.
- R2: The control word (address 0) has these fields: bit 31 run, bit 30 direction (1 counts up, 0 counts down), bit 29 reload-on-alarm, bits 28:13 a 16-bit divider, bit 12 edge enable, bit 11 level enable, bit 10 alarm arm. Bits 9:0 read as 0.
- R3: The counter changes only on a prescaled tick while run is set. Each tick adds or subtracts 1 across the full 64 bits, with carry and borrow crossing bit 31.
- R4: A divider value N of 2 or more gives one tick every N clocks. A divider of 0 or 1 gives one tick every 2 clocks.
- R5: A write of any data to address 3 copies the live count into the read-back words, low half at address 1 and high half at address 2. These words then hold their value while the counter keeps moving.
- R6: The preload value is held at addresses 6 (low) and 7 (high). A write of any data to address 8 loads it into the counter. This load wins over a tick at the same edge.
- R7: While alarm arm is set and the count equals the compare value (address 4 low, address 5 high), an alarm event happens at the next edge. The event sets raw bit 0 and clears alarm arm.
- R8: If reload-on-alarm is set, the alarm event also loads the preload value into the counter.
- R9: `irq_level` is high while raw bit 0, enable bit 0 (address 9) and level enable are all set.
- R10: With edge enable and enable bit 0 set, each alarm event gives `irq_edge` high for exactly one clock.
- R11: Status (address 11) reads raw (address 10) AND enable. Writing a 1 to bit 0 of the clear register (address 12) clears raw bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_level | output | 1 | Level interrupt |
| irq_edge | output | 1 | One-clock edge interrupt pulse |

## Verification
The bench counts latency from the edge that commits a write:
- Control, preload and snapshot writes are visible on `reg_rdata` one clock later.
- The first tick lands N edges after run is committed.
- An alarm sets raw bit 0, disarms, and raises `irq_edge` one edge after the matching count is reached.

Each run window is opened and closed by register writes a known number of cycles apart. The expected count is therefore an exact function of the window length and the divider. All reads are scheduled one cycle at a time and compared in a monitor at the next edge, so every sample falls inside a settled cycle.

// File: rtl/alarm_timer64_pkg.sv
package alarm_timer64_pkg;
  localparam int BUS_W  = 32;
  localparam int CNT_W  = 2 * BUS_W;
  localparam int DIV_W  = 16;
  localparam int ADDR_W = 4;
  localparam int IRQ_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL      = 4'd0,
    A_SNAP_LO   = 4'd1,
    A_SNAP_HI   = 4'd2,
    A_SNAP_TRIG = 4'd3,
    A_ALM_LO    = 4'd4,
    A_ALM_HI    = 4'd5,
    A_LD_LO     = 4'd6,
    A_LD_HI     = 4'd7,
    A_LD_TRIG   = 4'd8,
    A_IRQ_EN    = 4'd9,
    A_IRQ_RAW   = 4'd10,
    A_IRQ_ST    = 4'd11,
    A_IRQ_CLR   = 4'd12
  } reg_addr_e;

  typedef struct packed {
    logic             run;
    logic             count_up;
    logic             reload_on_alarm;
    logic [DIV_W-1:0] div;
    logic             edge_en;
    logic             level_en;
    logic             alarm_arm;
    logic [9:0]       rsvd;
  } ctrl_t;
endpackage

// File: rtl/at64_prescaler.sv
module at64_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_LIMIT = DIV_W'(1);

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = (div < DIV_W'(2)) ? MIN_LIMIT : div - DIV_W'(1);
    tick  = run && (phase >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= '0;
    else if (!run)   phase <= '0;
    else if (tick)   phase <= '0;
    else             phase <= phase + DIV_W'(1);
  end

  // R4: stopped timer never ticks
  a_r4_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
  // R4: smallest spacing is two clocks
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/at64_counter.sv
module at64_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             count_up,
  input  logic             sw_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             alarm_arm,
  input  logic             reload_on_alarm,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] cnt,
  output logic             alarm_hit
);
  logic auto_load;

  always_comb begin
    alarm_hit = alarm_arm && (cnt == alarm_val);
    auto_load = alarm_hit && reload_on_alarm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (sw_load)        cnt <= load_val;
    else if (auto_load)      cnt <= load_val;
    else if (tick)           cnt <= count_up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
  end

  // R6: software load lands regardless of a simultaneous tick
  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> cnt == $past(load_val));
  // R8: alarm reload takes the preload value
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && reload_on_alarm) |=> cnt == $past(load_val));
  // R3: nothing moves the counter without a cause
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_load && !alarm_hit) |=> $stable(cnt));
endmodule

// File: rtl/at64_irq.sv
module at64_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [IRQ_W-1:0] clr_vec,
  input  logic [IRQ_W-1:0] en_vec,
  input  logic             edge_en,
  input  logic             level_en,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] status,
  output logic             irq_level,
  output logic             irq_edge
);
  logic [IRQ_W-1:0] clr_mask;

  always_comb begin
    clr_mask  = clr_wr ? clr_vec : '0;
    status    = raw & en_vec;
    irq_level = level_en && (|status);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw      <= '0;
      irq_edge <= 1'b0;
    end else begin
      raw      <= (raw & ~clr_mask) | set_vec;
      irq_edge <= edge_en && (|(set_vec & en_vec));
    end
  end

  // R11: a new event always leaves its raw bit set
  a_r11_raw_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> raw[0]);
  // R10: edge pulse is one clock wide
  a_r10_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge |=> !irq_edge);
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
  import alarm_timer64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              irq_level,
  output logic              irq_edge
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] snap_q, alarm_q, preload_q, cnt;
  logic [IRQ_W-1:0] irq_en_q, irq_raw, irq_st, irq_set;
  logic             tick, alarm_hit;
  logic             wr_snap, wr_load, wr_clr;

  always_comb begin
    wr_snap = reg_wr && (reg_addr == A_SNAP_TRIG);
    wr_load = reg_wr && (reg_addr == A_LD_TRIG);
    wr_clr  = reg_wr && (reg_addr == A_IRQ_CLR);
    irq_set = {{(IRQ_W-1){1'b0}}, alarm_hit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      snap_q    <= '0;
      alarm_q   <= '0;
      preload_q <= '0;
      irq_en_q  <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:   begin
                      ctrl_q      <= ctrl_t'(reg_wdata);
                      ctrl_q.rsvd <= '0;
                    end
          A_ALM_LO: alarm_q[BUS_W-1:0]       <= reg_wdata;
          A_ALM_HI: alarm_q[CNT_W-1:BUS_W]   <= reg_wdata;
          A_LD_LO:  preload_q[BUS_W-1:0]     <= reg_wdata;
          A_LD_HI:  preload_q[CNT_W-1:BUS_W] <= reg_wdata;
          A_IRQ_EN: irq_en_q <= reg_wdata[IRQ_W-1:0];
          default:  ;
        endcase
      end
      if (wr_snap)   snap_q <= cnt;
      if (alarm_hit) ctrl_q.alarm_arm <= 1'b0;
    end
  end

  at64_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .div(ctrl_q.div), .tick(tick)
  );

  at64_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count_up(ctrl_q.count_up),
    .sw_load(wr_load), .load_val(preload_q), .alarm_arm(ctrl_q.alarm_arm),
    .reload_on_alarm(ctrl_q.reload_on_alarm), .alarm_val(alarm_q),
    .cnt(cnt), .alarm_hit(alarm_hit)
  );

  at64_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(irq_set), .clr_wr(wr_clr),
    .clr_vec(reg_wdata[IRQ_W-1:0]), .en_vec(irq_en_q),
    .edge_en(ctrl_q.edge_en), .level_en(ctrl_q.level_en),
    .raw(irq_raw), .status(irq_st), .irq_level(irq_level), .irq_edge(irq_edge)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:    reg_rdata = BUS_W'(ctrl_q);
      A_SNAP_LO: reg_rdata = snap_q[BUS_W-1:0];
      A_SNAP_HI: reg_rdata = snap_q[CNT_W-1:BUS_W];
      A_ALM_LO:  reg_rdata = alarm_q[BUS_W-1:0];
      A_ALM_HI:  reg_rdata = alarm_q[CNT_W-1:BUS_W];
      A_LD_LO:   reg_rdata = preload_q[BUS_W-1:0];
      A_LD_HI:   reg_rdata = preload_q[CNT_W-1:BUS_W];
      A_IRQ_EN:  reg_rdata = BUS_W'(irq_en_q);
      A_IRQ_RAW: reg_rdata = BUS_W'(irq_raw);
      A_IRQ_ST:  reg_rdata = BUS_W'(irq_st);
      default:   reg_rdata = '0;
    endcase
  end

  // R7: an alarm event disarms the alarm
  a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> !ctrl_q.alarm_arm);
  // R5: read-back words move only on a snapshot write
  a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_snap |=> $stable(snap_q));
  // R2: reserved control bits stay zero
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> ctrl_q.rsvd == '0);
endmodule

// File: tb/alarm_timer64_bench.sv
module alarm_timer64_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_level, irq_edge;

  int checks = 0;
  int errors = 0;
  int edge_pulses = 0;
  bit done = 0;
  bit mon_req = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  alarm_timer64 u_alarm_timer64 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .irq_edge(irq_edge)
  );

  function automatic logic [31:0] cw(bit run, bit up, bit ar, int dv,
                                     bit edg, bit lvl, bit arm);
    return {run, up, ar, dv[15:0], edg, lvl, arm, 10'd0};
  endfunction

  // driver tasks: entered at a negedge, leave one cycle later at a negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    reg_addr = a; mon_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    mon_req = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, e);
    end
  endtask

  // monitor: compares reads at the edge closing the read cycle
  always @(posedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", t, reg_rdata, e);
      end
    end
    if (irq_edge) edge_pulses++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0,  32'h0, "R1 ctrl");
    rd(4'd1,  32'h0, "R1 snap_lo");
    rd(4'd10, 32'h0, "R1 raw");
    chk(irq_level, 1'b0, "R1 irq_level");
    chk(irq_edge,  1'b0, "R1 irq_edge");

    // R2 field layout, reserved bits dropped
    wr(4'd0, cw(0, 1, 1, 16'h1234, 1, 1, 0) | 32'h3FF);
    rd(4'd0, cw(0, 1, 1, 16'h1234, 1, 1, 0), "R2 ctrl layout");

    // R6 load while stopped
    wr(4'd6, 32'h10); wr(4'd7, 32'h1); wr(4'd8, 32'h0);
    wr(4'd3, 32'h0);
    rd(4'd1, 32'h10, "R6 load lo");
    rd(4'd2, 32'h1,  "R6 load hi");

    // R3/R4 up count, divider 4: 40-cycle window gives 10 ticks
    wr(4'd0, cw(1, 1, 0, 4, 0, 0, 0));
    repeat (39) @(negedge clk);
    wr(4'd0, cw(0, 1, 0, 4, 0, 0, 0));
    wr(4'd3, 32'h0);
    rd(4'd1, 32'h1A, "R4 div4 up lo");
    rd(4'd2, 32'h1,  "R3 up hi");
    // R5 snapshot holds while the counter runs
    wr(4'd0, cw(1, 1, 0, 4, 0, 0, 0));
    repeat (12) @(negedge clk);
    rd(4'd1, 32'h1A, "R5 snapshot stable");
    wr(4'd0, 32'h0);

    // R3/R4 down count across bit 31, divider 0 acts as 2
    wr(4'd6, 32'h3); wr(4'd7, 32'h1); wr(4'd8, 32'h0);
    wr(4'd0, cw(1, 0, 0, 0, 0, 0, 0));
    repeat (19) @(negedge clk);
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h0);
    rd(4'd1, 32'hFFFF_FFF9, "R4 div0 down lo");
    rd(4'd2, 32'h0,         "R3 borrow hi");

    // R7/R9/R10 alarm at 5, divider 2, no reload
    wr(4'd6, 32'h0); wr(4'd7, 32'h0); wr(4'd8, 32'h0);
    wr(4'd4, 32'h5); wr(4'd5, 32'h0); wr(4'd9, 32'h1);
    wr(4'd0, cw(1, 1, 0, 2, 1, 1, 1));
    repeat (20) @(negedge clk);
    rd(4'd0, cw(1, 1, 0, 2, 1, 1, 0), "R7 arm self-clear");
    wr(4'd0, cw(0, 1, 0, 2, 1, 1, 0));
    chk(edge_pulses == 1, 1'b1, "R10 single edge pulse");
    chk(irq_level, 1'b1, "R9 level high");
    rd(4'd10, 32'h1, "R7 raw set");
    rd(4'd11, 32'h1, "R11 status");

    // R11/R9 masking and clearing
    wr(4'd9, 32'h0);
    rd(4'd11, 32'h0, "R11 status masked");
    chk(irq_level, 1'b0, "R9 level masked");
    rd(4'd10, 32'h1, "R11 raw kept");
    wr(4'd12, 32'h1);
    rd(4'd10, 32'h0, "R11 raw cleared");
    wr(4'd9, 32'h1);

    // R8 autoreload: preload 100, alarm 103, 10-cycle window ends at 102
    wr(4'd6, 32'd100); wr(4'd8, 32'h0);
    wr(4'd4, 32'd103);
    wr(4'd0, cw(1, 1, 1, 2, 0, 0, 1));
    repeat (9) @(negedge clk);
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h0);
    rd(4'd1, 32'd102, "R8 autoreload count");
    rd(4'd10, 32'h1,  "R8 alarm raised");

    // R6 load collides with a tick and wins
    wr(4'd6, 32'd500);
    wr(4'd0, cw(1, 1, 0, 2, 0, 0, 0));
    @(negedge clk);
    wr(4'd8, 32'h0);
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h0);
    rd(4'd1, 32'd500, "R6 load beats tick");

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule